// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces horizontal sync, vertical sync, a data-enable strobe and zero-based pixel and line coordinates for a progressive-scan display. It runs entirely on the pixel clock. All timing is programmed through five 32-bit registers on a simple write-only bus. There is one register for the active size, one for horizontal porches and sync, one for vertical porches and sync, one for sync polarity and one for enable. Interlaced scanning is not supported.

Software programs the timing registers while the block is idle and then writes 1 to the enable register. At that moment the generator takes a private copy of every parameter and begins scanning at the start of horizontal sync on line 0 of vertical sync. A downstream pixel pipeline uses the data-enable strobe and the coordinates to decide when to fetch and present pixels.

Each line runs through four phases in a fixed order: sync, back porch, active, front porch. Each frame runs through the same four phases, counted in lines.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the block is idle. de_o is 0, both syncs are 0 and x_o and y_o are 0.
- R2: Register addresses and field layouts are as follows.
  - Address 0 is the size word: active height in bits 31:16 and active width in bits 15:0.
  - Address 1 is the horizontal word: back porch in bits 31:22, sync width in bits 21:11 and front porch in bits 10:0.
  - Address 2 is the vertical word, with the same layout as address 1 but counted in lines.
  - Address 3 is the polarity word.
  - Address 4 is the enable word, bit 0.
- R3: A write of 1 to the enable word while idle copies the programmed parameters. In the first cycle after that write edge, the generator is at pixel 0 of line 0, which is the first cycle of both syncs.
- R4: One line lasts sync + back porch + active width + front porch cycles. The horizontal sync is asserted for the first sync-width cycles of every line.
- R5: One frame lasts the same four-term sum of vertical fields, in lines. The vertical sync is asserted for the first vertical-sync-width lines.
- R6: de_o is high exactly when the pixel lies within [sync+back porch, sync+back porch+width) on a line that lies within the corresponding vertical window.
- R7: While de_o is high, x_o and y_o are the zero-based position inside the active area. While de_o is low, both read 0.
- R8: Polarity bit 0 inverts hsync_o and bit 1 inverts vsync_o. With the polarity word at 0, both syncs are active-high.
- R9: A write of 0 to the enable word stops scanning from the next cycle. de_o goes low, x_o and y_o go to 0, and each sync sits at its inactive level as set by the current polarity word.
- R10: Writes to the size, timing or polarity words while scanning have no effect on the outputs until the block is disabled and enabled again.
- R11: A write of 1 to the enable word while scanning does not restart or disturb the scan.
- R12: With an 800x480 active area, horizontal back/sync/front of 86/128/42 and vertical back/sync/front of 33/2/10, the line is 1056 cycles long. The first active pixel of a line is cycle 214, and the first active line is line 35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity per bit 0 of the polarity word |
| vsync_o | output | 1 | Vertical sync, polarity per bit 1 of the polarity word |
| de_o | output | 1 | Data enable, high inside the active area |
| x_o | output | 16 | Active-area pixel index |
| y_o | output | 16 | Active-area line index |

## Verification
Assertions check the following on every cycle:
- data enable stays low while idle;
- the active pixel index stays below the latched width;
- each counter stays below its period and returns to 0 after a wrap;
- the line counter moves only when a line ends.

Only the bench scenarios can show the complete behaviour. They compare every output, cycle by cycle, against positions computed arithmetically from the cycle count since enable. This covers the exact placement of sync and active windows, both polarities, and the isolation of the running scan from register writes and repeated enables. It also covers the reference 800x480 mode.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int REG_DW   = 32;
  localparam int REG_AW   = 3;
  localparam int ACT_W    = 16;
  localparam int BACK_W   = 10;
  localparam int SYNC_W   = 11;
  localparam int FRONT_W  = 11;

  typedef enum logic [REG_AW-1:0] {
    ADDR_SIZE = 3'd0,
    ADDR_HPAR = 3'd1,
    ADDR_VPAR = 3'd2,
    ADDR_POL  = 3'd3,
    ADDR_MODE = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic [BACK_W-1:0]  back;
    logic [SYNC_W-1:0]  sync;
    logic [FRONT_W-1:0] front;
    logic [ACT_W-1:0]   act;
  } axis_cfg_t;

  // porch word: back 31:22, sync 21:11, front 10:0
  function automatic axis_cfg_t unpack_axis(logic [REG_DW-1:0] porch_w,
                                            logic [ACT_W-1:0] act_len);
    axis_cfg_t c;
    c.back  = porch_w[31:22];
    c.sync  = porch_w[21:11];
    c.front = porch_w[10:0];
    c.act   = act_len;
    return c;
  endfunction
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic              run_o,
  output axis_cfg_t         h_cfg_o,
  output axis_cfg_t         v_cfg_o,
  output logic [1:0]        pol_o
);
  logic [REG_DW-1:0] size_q, hpar_q, vpar_q;
  logic [1:0]        pol_q, pol_sh_q;
  logic              run_q;
  axis_cfg_t         h_sh_q, v_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q   <= '0;
      hpar_q   <= '0;
      vpar_q   <= '0;
      pol_q    <= '0;
      pol_sh_q <= '0;
      run_q    <= 1'b0;
      h_sh_q   <= '0;
      v_sh_q   <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_SIZE: size_q <= wdata_i;
        ADDR_HPAR: hpar_q <= wdata_i;
        ADDR_VPAR: vpar_q <= wdata_i;
        ADDR_POL:  pol_q  <= wdata_i[1:0];
        ADDR_MODE: begin
          if (wdata_i[0] && !run_q) begin
            run_q    <= 1'b1;
            h_sh_q   <= unpack_axis(hpar_q, size_q[ACT_W-1:0]);
            v_sh_q   <= unpack_axis(vpar_q, size_q[REG_DW-1:ACT_W]);
            pol_sh_q <= pol_q;
          end else if (!wdata_i[0]) begin
            run_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign run_o   = run_q;
  assign h_cfg_o = h_sh_q;
  assign v_cfg_o = v_sh_q;
  assign pol_o   = run_q ? pol_sh_q : pol_q;

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> (run_q ? $stable(h_sh_q) && $stable(v_sh_q) : 1'b1)) // R10
    else $error("shadow changed while running");
endmodule

// File: rtl/rtg_axis_cnt.sv
module rtg_axis_cnt
  import rtg_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  axis_cfg_t        cfg_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             wrap_o,
  output logic             sync_o,
  output logic             act_o,
  output logic [ACT_W-1:0] coord_o
);
  logic [CNT_W-1:0] pos_q, total, act_start, act_end;
  logic [CNT_W:0]   pos_nxt;
  logic             last;

  assign act_start = CNT_W'(cfg_i.sync) + CNT_W'(cfg_i.back);
  assign act_end   = act_start + CNT_W'(cfg_i.act);
  assign total     = act_end + CNT_W'(cfg_i.front);
  assign pos_nxt   = {1'b0, pos_q} + 1'b1;
  assign last      = pos_nxt >= {1'b0, total};
  assign wrap_o    = step_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (clr_i)  pos_q <= '0;
    else if (step_i) pos_q <= last ? '0 : pos_nxt[CNT_W-1:0];
  end

  assign pos_o   = pos_q;
  assign sync_o  = pos_q < CNT_W'(cfg_i.sync);
  assign act_o   = (pos_q >= act_start) && (pos_q < act_end);
  assign coord_o = ACT_W'(pos_q - act_start);

  AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (total != '0) |-> (pos_q < total)) // R4
    else $error("position beyond period");
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (pos_q == '0)) // R5
    else $error("wrap did not return to zero");
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [ACT_W-1:0]  x_o,
  output logic [ACT_W-1:0]  y_o
);
  localparam int N_SYNC = 2;

  logic             run;
  axis_cfg_t        h_cfg, v_cfg;
  logic [1:0]       pol;
  logic [CNT_W-1:0] h_pos, v_pos;
  logic             h_wrap, v_wrap, h_sync, v_sync, h_act, v_act;
  logic [ACT_W-1:0] h_coord, v_coord;
  logic [N_SYNC-1:0] sync_raw, sync_out;

  rtg_regs i_regs (
    .clk_i, .rst_ni,
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .run_o   (run),
    .h_cfg_o (h_cfg),
    .v_cfg_o (v_cfg),
    .pol_o   (pol)
  );

  rtg_axis_cnt #(.CNT_W(CNT_W)) i_hcnt (
    .clk_i, .rst_ni,
    .clr_i   (!run),
    .step_i  (run),
    .cfg_i   (h_cfg),
    .pos_o   (h_pos),
    .wrap_o  (h_wrap),
    .sync_o  (h_sync),
    .act_o   (h_act),
    .coord_o (h_coord)
  );

  rtg_axis_cnt #(.CNT_W(CNT_W)) i_vcnt (
    .clk_i, .rst_ni,
    .clr_i   (!run),
    .step_i  (h_wrap),
    .cfg_i   (v_cfg),
    .pos_o   (v_pos),
    .wrap_o  (v_wrap),
    .sync_o  (v_sync),
    .act_o   (v_act),
    .coord_o (v_coord)
  );

  assign sync_raw = {v_sync, h_sync};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_pol
    assign sync_out[g] = (run & sync_raw[g]) ^ pol[g];
  end

  assign hsync_o = sync_out[0];
  assign vsync_o = sync_out[1];
  assign de_o    = run & h_act & v_act;
  assign x_o     = de_o ? h_coord : '0;
  assign y_o     = de_o ? v_coord : '0;

  AST_DE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !de_o) // R9
    else $error("data enable while idle");
  AST_X_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (x_o < h_cfg.act) && (y_o < v_cfg.act)) // R7
    else $error("coordinate outside active area");
  AST_VSTEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !h_wrap) |=> $stable(v_pos)) // R5
    else $error("line advanced mid-line");
  AST_VWRAP_ON_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_wrap |-> h_wrap) // R5
    else $error("frame wrap without line wrap");
endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        hs, vs, de;
  logic [15:0] xo, yo;

  int checks = 0, errors = 0;
  bit done = 0, chk_en = 0;
  string scen = "R1";

  always #5 clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .hsync_o(hs), .vsync_o(vs), .de_o(de),
    .x_o(xo), .y_o(yo)
  );

  // bench copy of the programmed values and the latched run state
  logic [31:0] b_size = '0, b_hpar = '0, b_vpar = '0;
  logic [1:0]  b_pol = '0, m_pol = '0;
  bit m_run = 0;
  int k = 0;
  int m_hb, m_hs, m_hf, m_ha, m_vb, m_vs, m_vf, m_va;

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_run) k <= k + 1;
      if (we) begin
        case (addr)
          3'd0: b_size <= wdata;
          3'd1: b_hpar <= wdata;
          3'd2: b_vpar <= wdata;
          3'd3: b_pol  <= wdata[1:0];
          3'd4: begin
            if (wdata[0] && !m_run) begin
              m_run <= 1; k <= 0; m_pol <= b_pol;
              m_hb <= int'(b_hpar[31:22]); m_hs <= int'(b_hpar[21:11]);
              m_hf <= int'(b_hpar[10:0]);  m_ha <= int'(b_size[15:0]);
              m_vb <= int'(b_vpar[31:22]); m_vs <= int'(b_vpar[21:11]);
              m_vf <= int'(b_vpar[10:0]);  m_va <= int'(b_size[31:16]);
            end else if (!wdata[0]) m_run <= 0;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 30)
        $display("FAIL %s [%s] k=%0d: actual %0d expected %0d", tag, scen, k, act, exp);
    end
  endtask

  int ll, fl, h, v, eh, ev, ea, ex, ey;
  logic [1:0] pp;
  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      eh = 0; ev = 0; ea = 0; ex = 0; ey = 0;
      pp = m_run ? m_pol : b_pol;
      if (m_run) begin
        ll = m_hb + m_hs + m_hf + m_ha;
        fl = m_vb + m_vs + m_vf + m_va;
        h  = k % ll;
        v  = (k / ll) % fl;
        eh = (h < m_hs) ? 1 : 0;
        ev = (v < m_vs) ? 1 : 0;
        ea = (h >= m_hs + m_hb && h < m_hs + m_hb + m_ha &&
              v >= m_vs + m_vb && v < m_vs + m_vb + m_va) ? 1 : 0;
        if (ea != 0) begin
          ex = h - m_hs - m_hb;
          ey = v - m_vs - m_vb;
        end
      end
      chk("R4 R8 hsync", int'(hs), eh ^ int'(pp[0]));
      chk("R5 R8 vsync", int'(vs), ev ^ int'(pp[1]));
      chk("R6 de", int'(de), ea);
      chk("R7 x", int'(xo), ex);
      chk("R7 y", int'(yo), ey);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int w, int ht, int hb, int hsw, int hf, int vb, int vsw, int vf, int p);
    wr(3'd0, (32'(ht) << 16) | 32'(w));
    wr(3'd1, (32'(hb) << 22) | (32'(hsw) << 11) | 32'(hf));
    wr(3'd2, (32'(vb) << 22) | (32'(vsw) << 11) | 32'(vf));
    wr(3'd3, 32'(p));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 hsync", int'(hs), 0);
    chk("R1 vsync", int'(vs), 0);
    chk("R1 de", int'(de), 0);
    chk("R1 x", int'(xo), 0);
    chk("R1 y", int'(yo), 0);
    chk_en = 1;

    scen = "R2 R3 R4 R5 basic";
    cfg(4, 3, 2, 1, 1, 1, 2, 1, 0);
    wr(3'd4, 1);
    idle(2 * 8 * 7 + 5);

    scen = "R9 idle with live polarity";
    wr(3'd4, 0);
    cfg(5, 2, 3, 2, 0, 0, 1, 2, 3);
    idle(5);

    scen = "R8 inverted";
    wr(3'd4, 1);
    idle(120);

    scen = "R10 writes while running";
    cfg(7, 4, 1, 1, 1, 1, 1, 1, 0);
    idle(60);

    scen = "R11 repeat enable";
    wr(3'd4, 1);
    idle(30);

    scen = "R9 stop";
    wr(3'd4, 0);
    idle(10);

    scen = "R10 relatch";
    wr(3'd4, 1);
    idle(120);
    wr(3'd4, 0);

    // near-exhaustive sweep of small timings
    for (int hb = 0; hb < 3; hb++)
      for (int hsw = 0; hsw < 3; hsw++)
        for (int hf = 0; hf < 2; hf++)
          for (int vsw = 1; vsw < 3; vsw++) begin
            scen = "R4 R5 R6 R7 sweep";
            cfg(2, 2, hb, hsw, hf, 1, vsw, 0, (hb + vsw) % 4);
            wr(3'd4, 1);
            idle((2 + hb + hsw + hf) * (3 + vsw) + 7);
            wr(3'd4, 0);
          end

    scen = "R12 800x480 reference";
    cfg(800, 480, 86, 128, 42, 33, 2, 10, 0);
    wr(3'd4, 1);
    idle(36 * 1056 + 300);
    wr(3'd4, 0);
    idle(4);

    finish_run();
  end
endmodule